// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation row vectors by a fixed N×N weight matrix on a square grid of multiply-accumulate cells. Each cell keeps one signed 8-bit weight. The weights are first shifted into the grid one vector per cycle and then stay in place. After that, activation rows can be presented one per clock. For each valid row `a`, the block returns `y[j] = sum over k of a[k] * W[k][j]` as N signed 32-bit results.

Each activation element travels rightwards along its grid row, one cell per clock. Each partial sum travels downwards along its grid column, one cell per clock, and gathers one product per cell. The time skew that the grid needs is applied inside the block. Element k of a row is delayed k cycles before it enters the grid. Column j is delayed by further registers at the bottom, so that all N results of a row leave together. Once the weights are loaded, nothing is fetched from outside the grid. A new weight set can only be loaded while the grid is empty.

Top module: `wsa_grid_mul`

## Requirements
- R1: While the grid is idle, each cycle with `w_load` high shifts every weight column down by one row and writes byte j of `w_bus` (bits 8j+7..8j) into row 0, column j. The vector given on the last of N consecutive load cycles therefore multiplies activation element 0, and the first one multiplies element N-1.
- R2: Stored weights are not changed by computation. Streaming the same rows again, without a new load, returns the same results.
- R3: Activation element k sits in `a_bus` bits 8k+7..8k, and all operands are two's-complement 8-bit values. Result j sits in `y_bus` bits 32j+31..32j and equals the signed sum over k of a[k]·W[k][j].
- R4: Rows may be presented on consecutive cycles. One full result row is produced per valid input row, with no stall.
- R5: If `a_valid` is high at a rising clock edge, `y_valid` is high for exactly one cycle, starting right after the edge that comes 2N-1 edges later. `y_valid` is never high otherwise.
- R6: Whenever `y_valid` is low, `y_bus` is zero. The content of `a_bus` has no effect in cycles where `a_valid` is low.
- R7: `w_load` has no effect when `a_valid` is high in the same cycle, or while any accepted row is still in flight.
- R8: Reset clears all weights and all pipeline state. During reset and right after it, `y_valid` and `y_bus` are zero. Rows streamed before any load give zero results.
- R9: Extreme operands (-128·-128, 127·-128) summed over N = 4 rows give exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_load | input | 1 | Request to shift one weight vector into the grid |
| w_bus | input | N*8 | Weight vector, byte j for column j |
| a_valid | input | 1 | Activation row present on `a_bus` |
| a_bus | input | N*8 | Activation row, byte k for element k |
| y_valid | output | 1 | Result row present on `y_bus` |
| y_bus | output | N*32 | Result row, word j for column j |

## Verification
Two functions can fall in the same cycle: a weight-load request and the streaming of activations. The load request can meet either a valid row at the input or rows that are still in flight. The bench provokes this by holding `w_load` high with a distinctive weight vector during the first rows of a stream and for two cycles after the last row. It then checks every output row against the weights that were loaded before the stream. A single load issued afterwards, on an idle grid, must shift the model's weights in exactly as R1 describes. This shows that the lockout is not just blocking all loads.

// File: rtl/wsa_grid_mul.sv
module wsa_grid_mul #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_load,
  input  logic [N*DW-1:0] w_bus,
  input  logic            a_valid,
  input  logic [N*DW-1:0] a_bus,
  output logic            y_valid,
  output logic [N*AW-1:0] y_bus
);
  localparam int LAT = 2*N - 1;
  localparam int PW  = 2*DW;

  logic [LAT:0] vpipe;
  logic         busy;
  logic         load_ok;

  logic signed [DW-1:0] wt     [N][N];
  logic signed [DW-1:0] wt_nx  [N][N];
  logic signed [DW-1:0] act    [N][N];
  logic signed [AW-1:0] ps     [N][N];
  logic signed [DW-1:0] row_in [N];
  logic signed [DW-1:0] pe_a   [N][N];
  logic signed [AW-1:0] pe_s   [N][N];
  logic signed [AW-1:0] mac    [N][N];
  logic [N*N*DW-1:0]    wt_flat;

  assign busy    = |vpipe;
  assign load_ok = w_load & ~a_valid & ~busy;
  assign y_valid = vpipe[LAT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-1:0], a_valid};

  genvar k, j;
  generate
    for (k = 0; k < N; k++) begin : g_skew
      logic signed [DW-1:0] gated;
      assign gated = a_valid ? a_bus[k*DW +: DW] : '0;
      if (k == 0) begin : g_dly
        assign row_in[k] = gated;
      end else begin : g_dly
        logic signed [DW-1:0] sk [k];
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            for (int i = 0; i < k; i++) sk[i] <= '0;
          end else begin
            sk[0] <= gated;
            for (int i = 1; i < k; i++) sk[i] <= sk[i-1];
          end
        assign row_in[k] = sk[k-1];
      end
    end

    for (k = 0; k < N; k++) begin : g_row
      for (j = 0; j < N; j++) begin : g_col
        logic signed [PW-1:0] prod;
        if (j == 0) begin : g_ain
          assign pe_a[k][j] = row_in[k];
        end else begin : g_ain
          assign pe_a[k][j] = act[k][j-1];
        end
        if (k == 0) begin : g_sin
          assign pe_s[k][j]  = '0;
          assign wt_nx[k][j] = w_bus[j*DW +: DW];
        end else begin : g_sin
          assign pe_s[k][j]  = ps[k-1][j];
          assign wt_nx[k][j] = wt[k-1][j];
        end
        assign prod      = PW'(pe_a[k][j]) * PW'(wt[k][j]);
        assign mac[k][j] = pe_s[k][j] + AW'(prod);
        assign wt_flat[(k*N+j)*DW +: DW] = wt[k][j];
      end
    end

    for (j = 0; j < N; j++) begin : g_out
      localparam int D = N - j;
      logic signed [AW-1:0] ds [D];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          for (int i = 0; i < D; i++) ds[i] <= '0;
        end else begin
          ds[0] <= ps[N-1][j];
          for (int i = 1; i < D; i++) ds[i] <= ds[i-1];
        end
      assign y_bus[j*AW +: AW] = ds[D-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          wt[r][c]  <= '0;
          act[r][c] <= '0;
          ps[r][c]  <= '0;
        end
    end else begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          if (load_ok) wt[r][c] <= wt_nx[r][c];
          act[r][c] <= pe_a[r][c];
          ps[r][c]  <= mac[r][c];
        end
    end

endmodule

// File: rtl/wsa_grid_mul_chk.sv
module wsa_grid_mul_chk #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              w_load,
  input logic              a_valid,
  input logic              y_valid,
  input logic              busy,
  input logic [N*AW-1:0]   y_bus,
  input logic [N*N*DW-1:0] wt_flat
);
  logic [2*N-1:0] seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else        seen <= {seen[2*N-2:0], a_valid};

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid == seen[2*N-1]); // R5

  AST_OUT_AFTER_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> $past(busy)); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid |-> (y_bus == '0)); // R6

  AST_LOAD_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (w_load && (a_valid || busy)) |=> $stable(wt_flat)); // R7

endmodule

bind wsa_grid_mul wsa_grid_mul_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .w_load  (w_load),
  .a_valid (a_valid),
  .y_valid (y_valid),
  .busy    (busy),
  .y_bus   (y_bus),
  .wt_flat (wt_flat)
);

// File: tb/wsa_grid_mul_tb.sv
module wsa_grid_mul_tb;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 32;

  localparam logic [N*DW:0] TAB [10] = '{
    {1'b1, 32'h04030201},
    {1'b1, 32'h807FFEFF},
    {1'b0, 32'hAAAAAAAA},
    {1'b1, 32'h40302010},
    {1'b1, 32'h00000000},
    {1'b0, 32'h55555555},
    {1'b1, 32'h80808080},
    {1'b1, 32'h7F7F7F7F},
    {1'b1, 32'hC133F005},
    {1'b1, 32'h00000001}
  };
  localparam logic [N*DW-1:0] W1 [N] = '{32'hFE02FF01, 32'h40302010, 32'h807F0100, 32'hF905FD03};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            w_load = 1'b0;
  logic [N*DW-1:0] w_bus = '0;
  logic            a_valid = 1'b0;
  logic [N*DW-1:0] a_bus = '0;
  logic            y_valid;
  logic [N*AW-1:0] y_bus;

  int checks = 0;
  int errors = 0;
  int cur_w [N][N];

  always #5 clk = ~clk;

  wsa_grid_mul #(.N(N), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_bus(w_bus),
    .a_valid(a_valid), .a_bus(a_bus), .y_valid(y_valid), .y_bus(y_bus)
  );

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [N*AW-1:0] got, input logic [N*AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [N*AW-1:0] expect_row(input logic [N*DW-1:0] a);
    logic [N*AW-1:0] res;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      for (int r = 0; r < N; r++) s += $signed(a[r*DW +: DW]) * cur_w[r][c];
      res[c*AW +: AW] = s;
    end
    return res;
  endfunction

  // R1: one idle load cycle shifts columns down, new vector into row 0
  task automatic load_vec(input logic [N*DW-1:0] v);
    @(negedge clk);
    a_valid = 1'b0;
    w_load  = 1'b1;
    w_bus   = v;
    for (int r = N-1; r > 0; r--)
      for (int c = 0; c < N; c++) cur_w[r][c] = cur_w[r-1][c];
    for (int c = 0; c < N; c++) cur_w[0][c] = $signed(v[c*DW +: DW]);
  endtask

  task automatic stream(input int first, input int cnt, input bit disturb, input string tag);
    for (int t = 0; t < cnt + 2*N; t++) begin
      logic [N*DW:0] e;
      @(negedge clk);
      if (t >= 2*N) begin
        e = TAB[first + t - 2*N];
        check_bit("R5 valid timing", y_valid, e[N*DW]);
        if (e[N*DW]) check_vec(tag, y_bus, expect_row(e[N*DW-1:0]));
        else         check_vec("R6 idle output", y_bus, '0);
      end else begin
        check_bit("R5 valid timing", y_valid, 1'b0);
        check_vec("R6 idle output", y_bus, '0);
      end
      if (t < cnt) begin
        a_valid = TAB[first + t][N*DW];
        a_bus   = TAB[first + t][N*DW-1:0];
      end else begin
        a_valid = 1'b0;
        a_bus   = 32'hDEADBEEF;
      end
      w_load = disturb && (t < cnt + 2);
      w_bus  = 32'h11111111;
    end
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) cur_w[r][c] = 0;
    repeat (3) @(negedge clk);
    check_bit("R8 reset valid", y_valid, 1'b0);
    check_vec("R8 reset data", y_bus, '0);
    rst_n = 1'b1;

    stream(0, 4, 1'b0, "R8 cleared weights give zero");

    for (int t = 0; t < N; t++) load_vec(W1[N-1-t]);
    stream(0, 10, 1'b0, "R3 dot product (R4 back-to-back)");

    stream(0, 10, 1'b1, "R7 load ignored while busy (R2 weights held)");

    load_vec(32'h01020304);
    stream(9, 1, 1'b0, "R1 shift order");

    for (int t = 0; t < N; t++) load_vec(32'h80808080);
    stream(6, 2, 1'b0, "R9 extreme operands");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule